// File: doc/BRIEF.md
# Serial Baud Strobe Generator

This block derives the timing pulses for a serial port from the peripheral clock. The clock is first cut down by a selectable prescaler. A programmable counter then divides it by N+1, which gives an internal tick. A post-divider, whose ratio depends on the mode, turns the tick into two pulses. The base strobe is the oversampling pulse that receive logic samples on. The bit strobe marks each bit boundary. In clock-synchronous mode the block also drives a square serial clock that is derived from the same tick.

Every output is a pulse, or a level, that is registered on the peripheral clock. No derived clock net exists. The configuration is loaded through a one-cycle parallel write. Each write also clears every divider stage, so the timing restarts from a known phase.

Top module: `baud_strobe_gen`

## Requirements
- R1: The clock-source select `cfg_clk_sel` sets the prescale factor P. The encoding is 2'b00 → 1, 2'b01 → 4, 2'b10 → 16 and 2'b11 → 64 peripheral clock cycles per prescaled step.
- R2: The divisor `cfg_divisor` (N, 0 to 255) divides the prescaled steps by N+1. The tick period is therefore T = P·(N+1) clock cycles.
- R3: In asynchronous mode (`cfg_sync`=0) the base strobe period depends on `cfg_dbl`. With `cfg_dbl`=0 it is 2·T cycles. With `cfg_dbl`=1 it is T cycles.
- R4: In asynchronous mode the bit strobe period is 16 base periods when `cfg_os8`=0 and 8 base periods when `cfg_os8`=1.
- R5: In synchronous mode (`cfg_sync`=1) the block behaves as follows.
  - The base strobe pulses once per tick, ignoring `cfg_dbl` and `cfg_os8`.
  - The bit strobe pulses every 4·T cycles.
  - `sclk_out` starts low after a write, toggles every 2·T cycles and rises first 2·T cycles after the write.
  - In asynchronous mode `sclk_out` stays low.
- R6: Every bit strobe coincides with a base strobe.
- R7: A write (`cfg_we`=1 at a rising edge) loads the new settings and clears all counters.
  - In the cycle after the write, neither strobe is high.
  - The first base strobe is high in the cycle that follows the clock edge one base period after the write edge.
  - The first bit strobe is high in the cycle that follows the edge one bit period after the write edge.
- R8: While `rst_n` is low, all outputs are low.
  - After reset the settings are select 2'b00, N=0, asynchronous, 16x, normal speed.
  - With these settings the base strobe repeats every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for all configuration fields; restarts the dividers |
| cfg_clk_sel | input | 2 | Prescaler select (1/4/16/64) |
| cfg_divisor | input | 8 | Divisor N; the counter divides by N+1 |
| cfg_sync | input | 1 | 1 = clock-synchronous mode, 0 = asynchronous |
| cfg_os8 | input | 1 | 1 = base clock 8x the bit rate, 0 = 16x |
| cfg_dbl | input | 1 | 1 = double-speed generator (asynchronous mode only) |
| base_stb | output | 1 | One-cycle base (oversampling) strobe |
| bit_stb | output | 1 | One-cycle bit-boundary strobe |
| sclk_out | output | 1 | Serial clock level in synchronous mode, low otherwise |

## Verification
The assertions check several invariants on every cycle:
- every bit strobe lands on a base strobe;
- a tick never appears without a prescaler step;
- both strobes are quiet in the cycle after a write;
- the serial clock stays low in asynchronous mode and changes only together with a base strobe.

The actual periods are closed-form products of the prescale, divisor and mode ratios, and so is the restart phase after a write. Only the bench's scenarios can show those. The bench measures first-pulse and second-pulse distances across all select codes, several divisors including 0 and 255, and every mode combination.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Prescale factor in clock cycles for a select code: 4^sel.
  function automatic int unsigned prescale_len(input logic [1:0] sel);
    return 32'd1 << (2 * sel);
  endfunction

  // Ticks per base event: 1 in sync or double speed, otherwise 2.
  function automatic int unsigned base_ratio(input logic sync, input logic dbl);
    return (sync || dbl) ? 32'd1 : 32'd2;
  endfunction

  // Base events per bit.
  function automatic int unsigned bit_ratio(input logic sync, input logic os8);
    if (sync) return 32'd4;
    return os8 ? 32'd8 : 32'd16;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = 2,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  import baud_pkg::*;
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last_val;

  assign last_val = PRE_W'(prescale_len(2'(sel)) - 1);
  assign step     = (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (step)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = step && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_post.sv
module baud_post #(
  parameter int BIT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic sync,
  input  logic os8,
  input  logic dbl,
  output logic base_ev,
  output logic bit_ev,
  output logic base_stb,
  output logic bit_stb,
  output logic sclk_out
);
  import baud_pkg::*;
  logic             half_q;
  logic [BIT_W-1:0] bcnt_q;
  logic [BIT_W-1:0] bit_last;
  logic             one_per_tick;
  logic             sclk_tgl;

  assign one_per_tick = (base_ratio(sync, dbl) == 32'd1);
  assign base_ev      = tick && (one_per_tick || half_q);
  assign bit_last     = BIT_W'(bit_ratio(sync, os8) - 1);
  assign bit_ev       = base_ev && (bcnt_q == bit_last);
  // Sync clock edges fall on the 2nd and 4th tick of each bit.
  assign sclk_tgl     = sync && base_ev && bcnt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      bcnt_q   <= '0;
      base_stb <= 1'b0;
      bit_stb  <= 1'b0;
      sclk_out <= 1'b0;
    end else if (clear) begin
      half_q   <= 1'b0;
      bcnt_q   <= '0;
      base_stb <= 1'b0;
      bit_stb  <= 1'b0;
      sclk_out <= 1'b0;
    end else begin
      if (tick && !one_per_tick) half_q <= ~half_q;
      if (bit_ev)       bcnt_q <= '0;
      else if (base_ev) bcnt_q <= bcnt_q + 1'b1;
      base_stb <= base_ev;
      bit_stb  <= bit_ev;
      if (sclk_tgl) sclk_out <= ~sclk_out;
    end
  end
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 8,
  parameter int BIT_W = 4,
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_sync,
  input  logic             cfg_os8,
  input  logic             cfg_dbl,
  output logic             base_stb,
  output logic             bit_stb,
  output logic             sclk_out
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic             sync_q, os8_q, dbl_q;
  // Internal events brought out for the checker.
  logic             pre_step;
  logic             tick;
  logic             base_ev;
  logic             bit_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      div_q  <= '0;
      sync_q <= 1'b0;
      os8_q  <= 1'b0;
      dbl_q  <= 1'b0;
    end else if (cfg_we) begin
      sel_q  <= cfg_clk_sel;
      div_q  <= cfg_divisor;
      sync_q <= cfg_sync;
      os8_q  <= cfg_os8;
      dbl_q  <= cfg_dbl;
    end
  end

  baud_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(cfg_we), .sel(sel_q), .step(pre_step)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(cfg_we), .step(pre_step),
    .limit(div_q), .tick(tick)
  );

  baud_post #(.BIT_W(BIT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(cfg_we), .tick(tick),
    .sync(sync_q), .os8(os8_q), .dbl(dbl_q),
    .base_ev(base_ev), .bit_ev(bit_ev),
    .base_stb(base_stb), .bit_stb(bit_stb), .sclk_out(sclk_out)
  );
endmodule

// File: rtl/baud_strobe_gen_chk.sv
module baud_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic sync_q,
  input logic pre_step,
  input logic tick,
  input logic base_stb,
  input logic bit_stb,
  input logic sclk_out
);
  // R6: a bit boundary is always also a base sample point
  a_r6_bit_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> base_stb);

  // R2: the divider only advances on a prescaler step
  a_r2_tick_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pre_step);

  // R7: write clears strobes for the following cycle
  a_r7_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!base_stb && !bit_stb));

  // R5: serial clock low in asynchronous mode
  a_r5_sclk_low_async: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && !cfg_we) |=> !sclk_out);

  // R5: serial clock edges only alongside a base strobe (or a write clearing it)
  a_r5_sclk_moves_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(sclk_out) || base_stb));
endmodule

bind baud_strobe_gen baud_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .sync_q(sync_q),
  .pre_step(pre_step), .tick(tick), .base_stb(base_stb),
  .bit_stb(bit_stb), .sclk_out(sclk_out)
);

// File: tb/tb_baud_strobe_gen.sv
module tb_baud_strobe_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_clk_sel = '0;
  logic [7:0] cfg_divisor = '0;
  logic       cfg_sync = 1'b0, cfg_os8 = 1'b0, cfg_dbl = 1'b0;
  logic       base_stb, bit_stb, sclk_out;

  int cyc = 0;
  int c0 = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clk_sel(cfg_clk_sel),
    .cfg_divisor(cfg_divisor), .cfg_sync(cfg_sync), .cfg_os8(cfg_os8),
    .cfg_dbl(cfg_dbl), .base_stb(base_stb), .bit_stb(bit_stb),
    .sclk_out(sclk_out)
  );

  task automatic check_int(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Write a configuration; returns with c0 = cycle index of the write edge.
  task automatic do_write(input logic [1:0] sel, input int n,
                          input logic sy, input logic o8, input logic db);
    @(negedge clk);
    cfg_we = 1'b1; cfg_clk_sel = sel; cfg_divisor = 8'(n);
    cfg_sync = sy; cfg_os8 = o8; cfg_dbl = db;
    @(negedge clk);
    cfg_we = 1'b0;
    c0 = cyc;
  endtask

  // Configure, then measure strobe timing against closed-form periods.
  task automatic run_case(input string name, input logic [1:0] sel, input int n,
                          input logic sy, input logic o8, input logic db);
    int tick_p, base_p, bit_p, k;
    int first_base, first_bit, second_bit, nbase, sclk_rise, sclk_fall;
    logic sclk_prev, sclk_async_hi;
    tick_p = (1 << (2 * sel)) * (n + 1);          // R1, R2
    base_p = (sy || db) ? tick_p : 2 * tick_p;    // R3, R5
    bit_p  = sy ? 4 * tick_p : (o8 ? 8 : 16) * base_p; // R4, R5
    first_base = -1; first_bit = -1; second_bit = -1; nbase = 0;
    sclk_rise = -1; sclk_fall = -1; sclk_async_hi = 1'b0;
    do_write(sel, n, sy, o8, db);
    // R7: nothing in the cycle after the write
    check_int({name, " R7 strobes after write"}, int'(base_stb) + int'(bit_stb), 0);
    sclk_prev = sclk_out;
    k = 0;
    while (second_bit < 0 && k <= 2 * bit_p + 4) begin
      @(negedge clk);
      k = cyc - c0;
      if (base_stb) begin
        nbase++;
        if (first_base < 0) first_base = k;
      end
      if (bit_stb) begin
        if (first_bit < 0) first_bit = k;
        else second_bit = k;
      end
      if (!sy && sclk_out) sclk_async_hi = 1'b1;
      if (sclk_out && !sclk_prev && sclk_rise < 0) sclk_rise = k;
      if (!sclk_out && sclk_prev && sclk_fall < 0) sclk_fall = k;
      sclk_prev = sclk_out;
    end
    check_int({name, " R3/R7 first base strobe"}, first_base, base_p);
    check_int({name, " R4/R7 first bit strobe"}, first_bit, bit_p);
    check_int({name, " R4 second bit strobe"}, second_bit, 2 * bit_p);
    check_int({name, " R3 base pulses in two bits"}, nbase, 2 * bit_p / base_p);
    if (sy) begin
      check_int({name, " R5 sclk first rise"}, sclk_rise, 2 * tick_p);
      check_int({name, " R5 sclk first fall"}, sclk_fall, 4 * tick_p);
    end else begin
      check_int({name, " R5 sclk low in async"}, int'(sclk_async_hi), 0);
    end
  endtask

  // R8: reset state and default settings.
  task automatic test_reset();
    int prev, gap;
    check_int("R8 outputs in reset", int'(base_stb) + int'(bit_stb) + int'(sclk_out), 0);
    @(negedge clk); rst_n = 1'b1;
    prev = -1; gap = -1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (base_stb) begin
        if (prev >= 0 && gap < 0) gap = cyc - prev;
        prev = cyc;
      end
    end
    check_int("R8 default base period", gap, 2);
  endtask

  // R7: a rewrite mid-period restarts the phase.
  task automatic test_restart();
    do_write(2'b01, 2, 1'b0, 1'b1, 1'b0);
    repeat (101) @(negedge clk);
    run_case("restart", 2'b01, 2, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        run_case("sel0 N0 16x", 2'b00, 0, 1'b0, 1'b0, 1'b0);     // R1
        run_case("sel1 N2 8x", 2'b01, 2, 1'b0, 1'b1, 1'b0);      // R1 R4
        run_case("sel2 N1 dbl16", 2'b10, 1, 1'b0, 1'b0, 1'b1);   // R1 R3
        run_case("sel3 N0 dbl8", 2'b11, 0, 1'b0, 1'b1, 1'b1);    // R1 R3
        run_case("sel1 N0 dbl8", 2'b01, 0, 1'b0, 1'b1, 1'b1);
        run_case("sel0 N255 16x", 2'b00, 255, 1'b0, 1'b0, 1'b0); // R2
        run_case("sync N255", 2'b00, 255, 1'b1, 1'b0, 1'b0);     // R5
        run_case("sync sel3 N3", 2'b11, 3, 1'b1, 1'b1, 1'b1);    // R5
        run_case("sync sel0 N0", 2'b00, 0, 1'b1, 1'b0, 1'b0);    // R5 R6
        test_restart();
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_checks++; n_errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule